// File: doc/BRIEF.md
# Serial Receiver with Three-Sample Voting

This block takes an asynchronous serial line and turns each frame on it into a 12-bit word holding the received character and its error status. It runs off the system clock, and a one-cycle enable pulse at sixteen times the bit rate advances it. Idle line level is high. A falling edge starts a start-bit check. Every bit of the frame, the start bit included, is decided by a two-of-three vote over samples taken at ticks 7, 8 and 9 of that bit.

The decided words go into a receive store. That store works either as a 32-entry FIFO or as a single-word holding register, chosen by a mode input. A consumer drains the store through a show-ahead read port with empty and full flags. Line settings are static inputs: character length (5 to 8 bits), parity enable and sense, and one or two stop bits.

Top module: `serial_rx_vote`

## Requirements
- R1: After reset, rx_empty is 1, rx_full is 0 and rx_busy is 0.
- R2: A high-to-low change seen on a tick starts a start-bit check at tick 0. The start bit is accepted only if at least two of the samples at ticks 7, 8 and 9 are low. Otherwise the receiver returns to idle (rx_busy 0) and stores nothing.
- R3: Each later bit occupies 16 ticks and takes the majority of its samples at bit ticks 7, 8 and 9. A one-tick wrong value at tick 8 does not change the decided bit.
- R4: Data arrive least significant bit first. cfg_len values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The data field is word bits 7:0, and its unused upper bits read 0.
- R5: When cfg_par_en is 1, one parity bit follows the data. Even parity applies when cfg_par_odd is 0 and odd parity when it is 1. A mismatch sets word bit 9.
- R6: cfg_stop2 selects two stop bits instead of one. Word bit 8 (framing) is set if any stop bit votes low.
- R7: Word bit 10 (break) is set when every data, parity and stop bit of the frame votes low.
- R8: A word is stored only when the final stop bit has been decided. rx_busy stays 1 and the store is unchanged up to that point.
- R9: With cfg_fifo_en 1, the store keeps up to 32 words in arrival order, and rx_full is 1 exactly when it holds 32.
- R10: With cfg_fifo_en 0, the store keeps one word, and rx_full is 1 while it holds it.
- R11: A frame that completes while the store is full is dropped, and bit 11 (overrun) of the most recently stored word is set. Words are stored with bit 11 at 0.
- R12: rd_data shows the oldest stored word. A cycle with rd_en 1 and rx_empty 0 removes that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rx_in | input | 1 | Serial line, high when idle |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_fifo_en | input | 1 | 1 selects 32-word FIFO, 0 single word |
| rd_en | input | 1 | Remove the oldest word |
| rd_data | output | 12 | Oldest word: {overrun, break, parity, framing, data} |
| rx_empty | output | 1 | Store holds no word |
| rx_full | output | 1 | Store at capacity for the selected mode |
| rx_busy | output | 1 | A frame is being received |

## Verification
Two situations are hard to reach from the pins: a vote that must overrule one disagreeing sample, and an overrun mark landing on a word that is already stored. The stimulus drives the line one tick at a time. This lets it put a single inverted tick at the middle sample of a chosen bit, and cut a start pulse so it stays low through tick 7 only or through tick 8. It also fills the FIFO and then the single-word register without reading, sends one extra frame into each, and then drains the store to check which word carries the overrun mark.

// File: rtl/serial_rx_vote.sv
module serial_rx_vote #(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rx_in,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic        cfg_stop2,
  input  logic        cfg_fifo_en,
  input  logic        rd_en,
  output logic [11:0] rd_data,
  output logic        rx_empty,
  output logic        rx_full,
  output logic        rx_busy
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PONE = AW'(1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;

  st_t         state;
  logic [1:0]  sync;
  logic        prev, s0, s1, second;
  logic [3:0]  ph;
  logic [2:0]  bidx;
  logic [7:0]  sh;
  logic        par_acc, perr, fe, zall;
  logic [11:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;

  wire       rx_s   = sync[1];
  wire       vote   = (s0 & s1) | (s0 & rx_s) | (s1 & rx_s);
  wire       decide = tick16 && state != IDLE && ph == 4'd9;
  wire [3:0] nbits  = {2'b00, cfg_len} + 4'd5;
  wire       last_stop = !cfg_stop2 || second;
  wire       push   = decide && state == STOP && last_stop;
  wire       pop    = rd_en && cnt != '0;
  wire [7:0] dout   = sh >> (4'd8 - nbits);
  wire [11:0] word  = {1'b0, zall & ~vote, perr, fe | ~vote, dout};

  assign rx_empty = cnt == '0;
  assign rx_full  = cfg_fifo_en ? (cnt == CAP) : (cnt != '0);
  assign rx_busy  = state != IDLE;
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; prev <= 1'b1; ph <= '0; s0 <= 1'b1; s1 <= 1'b1;
      bidx <= '0; sh <= '0; par_acc <= 1'b0; perr <= 1'b0;
      fe <= 1'b0; zall <= 1'b0; second <= 1'b0;
    end else if (tick16) begin
      prev <= rx_s;
      if (state == IDLE) begin
        if (prev && !rx_s) begin
          state <= START;
          ph    <= 4'd1;
        end
      end else begin
        ph <= ph + 4'd1;
        if (ph == 4'd7) s0 <= rx_s;
        if (ph == 4'd8) s1 <= rx_s;
        if (ph == 4'd9) begin
          case (state)
            START: begin
              if (!vote) begin
                state <= DATA; bidx <= '0; sh <= '0; par_acc <= 1'b0;
                perr <= 1'b0; fe <= 1'b0; zall <= 1'b1; second <= 1'b0;
              end else begin
                state <= IDLE;
              end
            end
            DATA: begin
              sh      <= {vote, sh[7:1]};
              par_acc <= par_acc ^ vote;
              zall    <= zall & ~vote;
              bidx    <= bidx + 3'd1;
              if ({1'b0, bidx} == nbits - 4'd1)
                state <= cfg_par_en ? PAR : STOP;
            end
            PAR: begin
              perr  <= cfg_par_odd ? ~(par_acc ^ vote) : (par_acc ^ vote);
              zall  <= zall & ~vote;
              state <= STOP;
            end
            STOP: begin
              fe   <= fe | ~vote;
              zall <= zall & ~vote;
              if (last_stop) state <= IDLE;
              else           second <= 1'b1;
            end
            default: state <= IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !rx_full) mem[wp] <= word;
    else if (push)        mem[wp - PONE][11] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push && !rx_full) wp <= wp + PONE;
      if (pop)              rp <= rp + PONE;
      case ({push && !rx_full, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

module serial_rx_vote_chk #(
  parameter int DEPTH = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick16,
  input logic                     rd_en,
  input logic                     rx_empty,
  input logic                     rx_full,
  input logic                     rx_busy,
  input logic [$clog2(DEPTH):0]   cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  // R1
  empty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_empty && rx_full));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);

  // R8
  push_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick16) |-> cnt <= $past(cnt));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> $past(tick16));

  // R12
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_empty && !tick16) |=> cnt == $past(cnt) - 1'b1);
endmodule

bind serial_rx_vote serial_rx_vote_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rd_en(rd_en),
  .rx_empty(rx_empty), .rx_full(rx_full), .rx_busy(rx_busy), .cnt(cnt)
);

// File: tb/tb_serial_rx_vote.sv
module tb_serial_rx_vote;
  logic clk = 0, rst_n = 0, tick16 = 0, rx_in = 1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_fifo_en = 1, rd_en = 0;
  logic [11:0] rd_data;
  logic rx_empty, rx_full, rx_busy;
  logic [1:0] div = 0;

  int checks = 0, errors = 0;
  logic [11:0] m [0:31];
  int mcnt = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    div    <= div + 2'd1;
    tick16 <= (div == 2'd2);
  end

  serial_rx_vote dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_fifo_en(cfg_fifo_en), .rd_en(rd_en),
    .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full), .rx_busy(rx_busy)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic next_tick();
    @(negedge clk);
    while (!tick16) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input bit glitch);
    for (int t = 0; t < 16; t++) begin
      next_tick();
      rx_in = (glitch && t == 8) ? ~v : v;
    end
  endtask

  function automatic logic [7:0] dmask();
    return 8'hFF >> (3 - cfg_len);
  endfunction

  task automatic send_frame(input logic [7:0] d, input int gbit, input bit bad_par,
                            input bit bad_stop, input int start_lows);
    logic [7:0] dm;
    logic pb, brk;
    int nstop;
    dm = d & dmask();
    for (int t = 0; t < 16; t++) begin
      next_tick();
      rx_in = (t < start_lows) ? 1'b0 : 1'b1;
    end
    for (int i = 0; i < 5 + int'(cfg_len); i++) send_bit(dm[i], gbit == i);
    pb = (cfg_par_odd ? ~^dm : ^dm) ^ bad_par;
    if (cfg_par_en) send_bit(pb, 0);
    nstop = cfg_stop2 ? 2 : 1;
    for (int s = 0; s < nstop; s++) begin
      for (int t = 0; t < 16; t++) begin
        next_tick();
        rx_in = ~bad_stop;
        if (s == nstop - 1 && t == 5) begin
          chk("R8 busy before final stop", {11'd0, rx_busy}, 12'd1);
          chk("R8 store unchanged before final stop", {11'd0, rx_empty}, {11'd0, mcnt == 0});
        end
      end
    end
    next_tick(); rx_in = 1'b1;
    next_tick(); next_tick();
    brk = bad_stop && dm == 8'd0 && (!cfg_par_en || pb == 1'b0);
    if (mcnt < (cfg_fifo_en ? 32 : 1)) begin
      m[mcnt] = {1'b0, brk, cfg_par_en & bad_par, bad_stop, dm};
      mcnt++;
    end else begin
      m[mcnt-1][11] = 1'b1;
    end
    chk("R9/R10 empty flag", {11'd0, rx_empty}, {11'd0, mcnt == 0});
    chk("R9/R10 full flag", {11'd0, rx_full}, {11'd0, mcnt == (cfg_fifo_en ? 32 : 1)});
  endtask

  task automatic read_check(input string req);
    @(negedge clk);
    chk(req, rd_data, m[0]);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    for (int i = 0; i < 31; i++) m[i] = m[i+1];
    mcnt--;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk("R1 empty after reset", {11'd0, rx_empty}, 12'd1);
    chk("R1 full after reset", {11'd0, rx_full}, 12'd0);
    chk("R1 busy after reset", {11'd0, rx_busy}, 12'd0);
    rst_n = 1;
    repeat (20) next_tick();

    send_frame(8'hA5, -1, 0, 0, 16);
    read_check("R4 8N1 data A5");

    // R2 rejected start: low through tick 7 only
    for (int t = 0; t < 16; t++) begin next_tick(); rx_in = (t < 8) ? 1'b0 : 1'b1; end
    repeat (20) next_tick();
    chk("R2 rejected start leaves idle", {11'd0, rx_busy}, 12'd0);
    chk("R2 rejected start stores nothing", {11'd0, rx_empty}, 12'd1);

    // R2 marginal start: low through tick 8
    send_frame(8'h3C, -1, 0, 0, 9);
    read_check("R2 marginal start accepted");

    // R3 glitch at middle sample
    send_frame(8'h81, 0, 0, 0, 16);
    read_check("R3 glitch on bit 0");
    send_frame(8'h81, 7, 0, 0, 16);
    read_check("R3 glitch on bit 7");

    // R7 break with even parity and two stops
    cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 1;
    send_frame(8'h00, -1, 0, 1, 16);
    read_check("R7 break word");
    // R5 parity error odd
    cfg_par_odd = 1;
    send_frame(8'h5A, -1, 1, 0, 16);
    read_check("R5 odd parity error");
    // R6 framing with 5 bits
    cfg_len = 2'd0; cfg_par_en = 0;
    send_frame(8'hFF, -1, 0, 1, 16);
    read_check("R6 framing error 5-bit");

    // random frames
    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      int g;
      cfg_len = 2'($urandom_range(0, 3));
      cfg_par_en = 1'($urandom_range(0, 1));
      cfg_par_odd = 1'($urandom_range(0, 1));
      cfg_stop2 = 1'($urandom_range(0, 1));
      d = 8'($urandom);
      g = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 4)) : -1;
      send_frame(d, g, ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0), 16);
      read_check("R4/R5/R6 random frame");
    end

    // R9 / R11 FIFO fill and overrun
    cfg_len = 2'd3; cfg_par_en = 0; cfg_stop2 = 0; cfg_fifo_en = 1;
    for (int k = 0; k < 33; k++) send_frame(8'(k * 7 + 1), -1, 0, 0, 16);
    chk("R11 overrun mark on newest word", {11'd0, m[31][11]}, 12'd1);
    for (int k = 0; k < 32; k++) read_check("R9/R11/R12 fifo order");
    chk("R12 drained", {11'd0, rx_empty}, 12'd1);

    // R10 / R11 single-word mode
    cfg_fifo_en = 0;
    send_frame(8'h11, -1, 0, 0, 16);
    send_frame(8'h22, -1, 0, 0, 16);
    read_check("R10/R11 single word with overrun");
    chk("R10 empty after read", {11'd0, rx_empty}, 12'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule